// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block turns a 32-bit virtual address into a 24-bit physical address for 1 KB pages. It keeps 16 translations, each pairing a 22-bit virtual page number with a 14-bit physical frame number, a valid flag and a dirty flag. Every entry is compared at once against the page number of the lookup address. A match on a valid entry returns the frame number joined to the untouched 10-bit page offset in the same cycle. A lookup with no match raises a miss pulse, which kernel software takes as its cue to walk the page table.

After a miss, the kernel installs the missing translation through the fill port. The fill goes into the lowest-numbered empty entry. When every entry is in use, a round-robin pointer picks the entry to overwrite instead. In that cycle the block puts the victim's page number, frame number and dirty flag on the eviction port, so that the page table can record pages that were written. A write that hits marks its entry dirty. When a page is swapped out, the kernel removes its translation through the invalidate port.

Top module: `xlat_tlb`

## Requirements
- R1: A synchronous reset clears every valid flag and sets the replacement pointer to entry 0. The first lookup after reset misses.
- R2: When `lkReq` is high and a valid entry holds the page number `lkVaddr[31:10]`, `lkHit` is 1 and `lkPaddr` equals that entry's frame number in bits 23:10 with `lkVaddr[9:0]` in bits 9:0. Both appear in the same cycle as the request.
- R3: When `lkReq` is high and no valid entry matches, `lkMiss` is 1, `lkHit` is 0 and `lkPaddr` is 0. When `lkReq` is low, `lkHit`, `lkMiss` and `lkPaddr` are all 0.
- R4: A fill stores the page number and the frame number, sets the valid flag and clears the dirty flag. The new translation can be looked up from the next cycle. While any entry is invalid, the fill goes to the lowest-numbered invalid entry.
- R5: A write lookup (`lkWrite` = 1) that hits sets the dirty flag of the matching entry at the next clock edge. A read hit leaves the dirty flag unchanged.
- R6: A fill into a full buffer overwrites the entry chosen by the round-robin pointer. The pointer then moves one step, wrapping from 15 to 0.
- R7: In a cycle with a fill into a full buffer, `evictStrobe` is 1 and `evictVpn`, `evictPfn` and `evictDirty` show the victim's contents from before the overwrite. In every other cycle all four outputs are 0.
- R8: An invalidate request clears the valid flag of the entry holding `invVpn`, from the next cycle on. All other entries are left unchanged.
- R9: If a fill and a write hit target the same entry in one cycle, the fill wins: the new entry starts clean.
- R10: Fills into a buffer that is not full, including a fill into a slot freed by invalidation, do not move the replacement pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lkReq | input | 1 | Lookup request |
| lkWrite | input | 1 | Lookup is a write access |
| lkVaddr | input | 32 | Virtual address to translate |
| lkHit | output | 1 | Translation found |
| lkMiss | output | 1 | Miss exception pulse |
| lkPaddr | output | 24 | Translated physical address, 0 when no hit |
| fillReq | input | 1 | Install a translation |
| fillVpn | input | 22 | Virtual page number to install |
| fillPfn | input | 14 | Physical frame number to install |
| invReq | input | 1 | Invalidate request |
| invVpn | input | 22 | Page number to invalidate |
| evictStrobe | output | 1 | Eviction report valid this cycle |
| evictVpn | output | 22 | Victim page number |
| evictPfn | output | 14 | Victim frame number |
| evictDirty | output | 1 | Victim was written |

## Verification
The hardest case to reach is the same-cycle collision between a fill and a write hit on the entry the round-robin pointer selects. Its outcome shows up only as a clean dirty flag much later, when that entry is evicted again. To reach it, the stimulus first fills the buffer, then moves the pointer with further fills, and uses an invalidate-and-refill so that the pointer lands on a known slot. It then writes to that slot in the same cycle as the fill that replaces it. A further 16 fills cycle the pointer all the way round, and the eviction report for that slot must show it clean.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W    = 32;
  localparam int PA_W    = 24;
  localparam int OFF_W   = 10;
  localparam int ENTRIES = 16;
  localparam int VPN_W   = VA_W - OFF_W;
  localparam int PFN_W   = PA_W - OFF_W;
  localparam int IDX_W   = $clog2(ENTRIES);

  typedef struct packed {
    logic             fillEn;
    logic [IDX_W-1:0] fillIdx;
    logic             invEn;
    logic             markDirty;
  } tlbCmd_t;
endpackage

// File: rtl/xlat_tlb_store.sv
module xlat_tlb_store
  import xlat_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  tlbCmd_t            cmd,
  input  logic [VPN_W-1:0]   lkVpn,
  input  logic [VPN_W-1:0]   invVpn,
  input  logic [VPN_W-1:0]   fillVpn,
  input  logic [PFN_W-1:0]   fillPfn,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic [ENTRIES-1:0] lkMatch,
  output logic [ENTRIES-1:0] validVec,
  output logic [PFN_W-1:0]   hitPfn,
  output logic [VPN_W-1:0]   rdVpn,
  output logic [PFN_W-1:0]   rdPfn,
  output logic               rdDirty
);
  logic [VPN_W-1:0]   vpnQ [ENTRIES];
  logic [PFN_W-1:0]   pfnQ [ENTRIES];
  logic [ENTRIES-1:0] validQ;
  logic [ENTRIES-1:0] dirtyQ;
  logic [ENTRIES-1:0] invMatch;

  for (genvar g = 0; g < ENTRIES; g++) begin : gCmp
    assign lkMatch[g]  = validQ[g] && (vpnQ[g] == lkVpn);
    assign invMatch[g] = validQ[g] && (vpnQ[g] == invVpn);
  end

  assign validVec = validQ;

  // one-hot select of the matching frame number
  always_comb begin
    hitPfn = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (lkMatch[i]) hitPfn = hitPfn | pfnQ[i];
  end

  assign rdVpn   = vpnQ[rdIdx];
  assign rdPfn   = pfnQ[rdIdx];
  assign rdDirty = dirtyQ[rdIdx];

  // per-entry priority: fill, then invalidate, then dirty marking
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (rst) begin
        validQ[i] <= 1'b0;
        dirtyQ[i] <= 1'b0;
      end else if (cmd.fillEn && (cmd.fillIdx == IDX_W'(i))) begin
        vpnQ[i]   <= fillVpn;
        pfnQ[i]   <= fillPfn;
        validQ[i] <= 1'b1;
        dirtyQ[i] <= 1'b0;
      end else begin
        if (cmd.invEn && invMatch[i]) validQ[i] <= 1'b0;
        if (cmd.markDirty && lkMatch[i]) dirtyQ[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/xlat_tlb_ctrl.sv
module xlat_tlb_ctrl
  import xlat_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               lkReq,
  input  logic               lkWrite,
  input  logic               fillReq,
  input  logic               invReq,
  input  logic [ENTRIES-1:0] lkMatch,
  input  logic [ENTRIES-1:0] validVec,
  output tlbCmd_t            cmd,
  output logic               lkHit,
  output logic               lkMiss,
  output logic               evictStrobe
);
  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] freeIdx;
  logic             isFull;
  logic             anyMatch;

  assign isFull   = &validVec;
  assign anyMatch = |lkMatch;

  // lowest-numbered invalid entry
  always_comb begin
    freeIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!validVec[i]) freeIdx = IDX_W'(i);
  end

  assign lkHit  = lkReq && anyMatch;
  assign lkMiss = lkReq && !anyMatch;

  assign cmd.fillEn    = fillReq;
  assign cmd.fillIdx   = isFull ? rrPtr : freeIdx;
  assign cmd.invEn     = invReq;
  assign cmd.markDirty = lkReq && lkWrite && anyMatch;

  assign evictStrobe = fillReq && isFull;

  always_ff @(posedge clk) begin
    if (rst)
      rrPtr <= '0;
    else if (fillReq && isFull)
      rrPtr <= (rrPtr == IDX_W'(ENTRIES - 1)) ? '0 : rrPtr + 1'b1;
  end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              lkReq,
  input  logic              lkWrite,
  input  logic [VA_W-1:0]   lkVaddr,
  output logic              lkHit,
  output logic              lkMiss,
  output logic [PA_W-1:0]   lkPaddr,
  input  logic              fillReq,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [PFN_W-1:0]  fillPfn,
  input  logic              invReq,
  input  logic [VPN_W-1:0]  invVpn,
  output logic              evictStrobe,
  output logic [VPN_W-1:0]  evictVpn,
  output logic [PFN_W-1:0]  evictPfn,
  output logic              evictDirty
);
  tlbCmd_t            cmd;
  logic [ENTRIES-1:0] lkMatch;
  logic [ENTRIES-1:0] validVec;
  logic [PFN_W-1:0]   hitPfn;
  logic [VPN_W-1:0]   rdVpn;
  logic [PFN_W-1:0]   rdPfn;
  logic               rdDirty;

  xlat_tlb_ctrl u_ctrl (
    .clk(clk), .rst(rst), .lkReq(lkReq), .lkWrite(lkWrite),
    .fillReq(fillReq), .invReq(invReq), .lkMatch(lkMatch),
    .validVec(validVec), .cmd(cmd), .lkHit(lkHit), .lkMiss(lkMiss),
    .evictStrobe(evictStrobe)
  );

  xlat_tlb_store u_store (
    .clk(clk), .rst(rst), .cmd(cmd), .lkVpn(lkVaddr[VA_W-1:OFF_W]),
    .invVpn(invVpn), .fillVpn(fillVpn), .fillPfn(fillPfn),
    .rdIdx(cmd.fillIdx), .lkMatch(lkMatch), .validVec(validVec),
    .hitPfn(hitPfn), .rdVpn(rdVpn), .rdPfn(rdPfn), .rdDirty(rdDirty)
  );

  assign lkPaddr    = lkHit ? {hitPfn, lkVaddr[OFF_W-1:0]} : '0;
  assign evictVpn   = evictStrobe ? rdVpn : '0;
  assign evictPfn   = evictStrobe ? rdPfn : '0;
  assign evictDirty = evictStrobe && rdDirty;
endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk
  import xlat_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             lkReq,
  input logic [VA_W-1:0]  lkVaddr,
  input logic             lkHit,
  input logic             lkMiss,
  input logic [PA_W-1:0]  lkPaddr,
  input logic             fillReq,
  input logic [VPN_W-1:0] fillVpn,
  input logic [PFN_W-1:0] fillPfn,
  input logic             invReq,
  input logic [VPN_W-1:0] invVpn,
  input logic             evictStrobe,
  input logic [VPN_W-1:0] evictVpn,
  input logic             evictDirty
);
  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !lkReq |-> (!lkHit && !lkMiss && lkPaddr == '0));

  assert_miss_no_addr_R3: assert property (@(posedge clk) disable iff (rst)
    lkMiss |-> (!lkHit && lkPaddr == '0));

  assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && lkReq) |-> lkMiss);

  assert_evict_needs_fill_R7: assert property (@(posedge clk) disable iff (rst)
    !fillReq |-> (!evictStrobe && evictVpn == '0 && !evictDirty));

  assert_fill_visible_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fillReq) && lkReq &&
     lkVaddr[VA_W-1:OFF_W] == $past(fillVpn))
    |-> (lkHit && lkPaddr[PA_W-1:OFF_W] == $past(fillPfn)));

  assert_inv_removes_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(invReq) && !$past(fillReq) && lkReq &&
     lkVaddr[VA_W-1:OFF_W] == $past(invVpn)) |-> lkMiss);
endmodule

bind xlat_tlb xlat_tlb_chk u_chk (
  .clk(clk), .rst(rst), .lkReq(lkReq), .lkVaddr(lkVaddr), .lkHit(lkHit),
  .lkMiss(lkMiss), .lkPaddr(lkPaddr), .fillReq(fillReq), .fillVpn(fillVpn),
  .fillPfn(fillPfn), .invReq(invReq), .invVpn(invVpn),
  .evictStrobe(evictStrobe), .evictVpn(evictVpn), .evictDirty(evictDirty)
);

// File: tb/xlat_tlb_tb.sv
`timescale 1ns/100ps
module xlat_tlb_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lkReq = 1'b0, lkWrite = 1'b0;
  logic [31:0] lkVaddr = '0;
  logic        lkHit, lkMiss;
  logic [23:0] lkPaddr;
  logic        fillReq = 1'b0;
  logic [21:0] fillVpn = '0;
  logic [13:0] fillPfn = '0;
  logic        invReq = 1'b0;
  logic [21:0] invVpn = '0;
  logic        evictStrobe, evictDirty;
  logic [21:0] evictVpn;
  logic [13:0] evictPfn;

  always #2.5 clk = ~clk;

  xlat_tlb u_dut (
    .clk(clk), .rst(rst), .lkReq(lkReq), .lkWrite(lkWrite), .lkVaddr(lkVaddr),
    .lkHit(lkHit), .lkMiss(lkMiss), .lkPaddr(lkPaddr), .fillReq(fillReq),
    .fillVpn(fillVpn), .fillPfn(fillPfn), .invReq(invReq), .invVpn(invVpn),
    .evictStrobe(evictStrobe), .evictVpn(evictVpn), .evictPfn(evictPfn),
    .evictDirty(evictDirty)
  );

  typedef struct {
    string       tag;
    logic        hit, miss;
    logic [23:0] pa;
    logic        evs;
    logic [21:0] evv;
    logic [13:0] evp;
    logic        evd;
  } expItem_t;

  expItem_t expQ[$];
  int nChecks = 0, nFails = 0;
  bit done = 0;

  // reference state derived from the requirements
  logic [21:0] mVpn [16];
  logic [13:0] mPfn [16];
  logic        mVal [16];
  logic        mDirty [16];
  int          mPtr = 0;

  function automatic logic [21:0] vpnOf(int k);
    return 22'h2A000 + 22'(k * 193);
  endfunction
  function automatic logic [13:0] pfnOf(int k);
    return 14'h0C0 + 14'(k);
  endfunction

  task automatic step(input logic rq, input logic wr, input logic [31:0] va,
                      input logic fr, input logic [21:0] fv, input logic [13:0] fp,
                      input logic ir, input logic [21:0] iv, input string tag);
    expItem_t e;
    bit hit = 0, full = 1;
    int hIdx = 0, fIdx = -1;
    @(negedge clk);
    lkReq = rq; lkWrite = wr; lkVaddr = va;
    fillReq = fr; fillVpn = fv; fillPfn = fp;
    invReq = ir; invVpn = iv;
    for (int i = 0; i < 16; i++)
      if (mVal[i] && mVpn[i] == va[31:10]) begin hit = 1; hIdx = i; end
    for (int i = 15; i >= 0; i--)
      if (!mVal[i]) begin full = 0; fIdx = i; end
    if (full) fIdx = mPtr;
    e.tag  = tag;
    e.hit  = rq && hit;
    e.miss = rq && !hit;
    e.pa   = (rq && hit) ? {mPfn[hIdx], va[9:0]} : 24'h0;
    e.evs  = fr && full;
    e.evv  = e.evs ? mVpn[fIdx] : 22'h0;
    e.evp  = e.evs ? mPfn[fIdx] : 14'h0;
    e.evd  = e.evs && mDirty[fIdx];
    expQ.push_back(e);
    for (int i = 0; i < 16; i++) begin
      if (fr && i == fIdx) begin
        mVpn[i] = fv; mPfn[i] = fp; mVal[i] = 1; mDirty[i] = 0;
      end else begin
        if (ir && mVal[i] && mVpn[i] == iv) mVal[i] = 0;
        if (rq && wr && hit && i == hIdx) mDirty[i] = 1;
      end
    end
    if (fr && full) mPtr = (mPtr + 1) % 16;
  endtask

  // monitor: samples 1 ns after the driving edge, well before the next rising edge
  always @(negedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      nChecks++;
      if (lkHit !== e.hit || lkMiss !== e.miss || lkPaddr !== e.pa ||
          evictStrobe !== e.evs || evictVpn !== e.evv || evictPfn !== e.evp ||
          evictDirty !== e.evd) begin
        nFails++;
        $display("FAIL %s: got hit=%0b miss=%0b pa=%h ev=%0b/%h/%h/%0b exp hit=%0b miss=%0b pa=%h ev=%0b/%h/%h/%0b",
                 e.tag, lkHit, lkMiss, lkPaddr, evictStrobe, evictVpn, evictPfn, evictDirty,
                 e.hit, e.miss, e.pa, e.evs, e.evv, e.evp, e.evd);
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mVal[i] = 0; mDirty[i] = 0; mVpn[i] = '0; mPfn[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    nChecks++;  // R7 quiet eviction port while held in reset
    if (evictStrobe !== 1'b0 || evictVpn !== '0) begin
      nFails++;
      $display("FAIL R7 reset: got ev=%0b/%h exp 0/0", evictStrobe, evictVpn);
    end
    rst = 1'b0;

    step(1, 0, {vpnOf(99), 10'h011}, 0, 0, 0, 0, 0, "R1 lookup after reset misses");
    for (int k = 0; k < 16; k++)
      step(1, 0, {vpnOf(200), 10'h0}, 1, vpnOf(k), pfnOf(k), 0, 0, "R4 R3 fill free entry, lookup misses");
    for (int k = 0; k < 16; k++)
      step(1, 0, {vpnOf(k), 10'(k * 61)}, 0, 0, 0, 0, 0, "R2 hit translation");
    step(1, 1, {vpnOf(2), 10'h3FF}, 0, 0, 0, 0, 0, "R5 write hit");
    step(1, 0, {vpnOf(3), 10'h000}, 0, 0, 0, 0, 0, "R5 read hit");
    step(0, 1, {vpnOf(1), 10'h155}, 0, 0, 0, 0, 0, "R3 no request gives no result");
    step(0, 0, 32'h0, 1, vpnOf(16), pfnOf(16), 0, 0, "R6 R7 evict entry 0 clean");
    step(0, 0, 32'h0, 1, vpnOf(17), pfnOf(17), 0, 0, "R6 R7 evict entry 1 clean");
    step(0, 0, 32'h0, 1, vpnOf(18), pfnOf(18), 0, 0, "R5 R7 evict entry 2 dirty");
    step(1, 0, {vpnOf(16), 10'h2A}, 0, 0, 0, 1, vpnOf(4), "R8 invalidate, other page still hits");
    step(1, 0, {vpnOf(4), 10'h2A}, 0, 0, 0, 0, 0, "R8 invalidated page misses");
    step(1, 0, {vpnOf(6), 10'h2B}, 0, 0, 0, 0, 0, "R8 other entries kept");
    step(0, 0, 32'h0, 1, vpnOf(19), pfnOf(19), 0, 0, "R10 R4 refill freed slot, no eviction");
    step(1, 0, {vpnOf(19), 10'h1}, 1, vpnOf(20), pfnOf(20), 0, 0, "R10 pointer held, evict entry 3 clean");
    step(1, 1, {vpnOf(19), 10'h2}, 1, vpnOf(21), pfnOf(21), 0, 0, "R9 fill collides with write hit");
    for (int k = 22; k < 38; k++)
      step(1, (k % 3) == 0, {vpnOf(k - 8), 10'(k)}, 1, vpnOf(k), pfnOf(k), 0, 0, "R9 R6 R5 wrap round eviction");
    step(1, 0, {vpnOf(21), 10'h0}, 0, 0, 0, 0, 0, "R6 victim gone after overwrite");
    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule